// File: doc/BRIEF.md
# Two-Mode System Clock Rate Controller

This block sets the clock rate of a microcontroller core from one small control register. A free-running base clock drives the block, and the block produces clock-enable strobes rather than gated clocks. There are three strobes. The bus-master strobe paces the processor. The chip strobe paces everything else on the chip. The clock-output strobe drives the external clock pin and always matches the chip strobe.

A mode bit decides what the 3-bit rate field does. With the mode bit clear, the field slows only the bus master, to any power-of-two ratio from 2 to 32. The chip strobe stays high on every cycle. With the mode bit set, the field divides the clock for the whole chip, to a ratio of 2, 4 or 8. The bus master then follows the chip strobe.

Software may change the rate while the block is running. A new setting is held back until the next common boundary of all the ratios. This prevents a strobe period shorter than the old or the new ratio. Software should write the mode bit first and the rate field in a later write.

Top module: `sysclk_rate_ctrl`

## Requirements
- R1: After reset the register reads 0x00, and all three strobes are high on every cycle.
- R2: A write stores data bit 5 as the mode bit and data bits 2:0 as the rate field. Read data returns them in the same positions. Bits 7, 6, 4 and 3 always read 0, whatever was written to them.
- R3: A 5-bit cycle count runs freely from 0 in the first cycle after reset. With the mode bit at 0, rate code 0 keeps the bus-master strobe high on every cycle. Code c in 1..5 asserts it only in cycles where count mod 2^c equals 2^c−1.
- R4: With the mode bit at 0, the chip strobe is high on every cycle, whatever the rate field holds.
- R5: With the mode bit at 1, rate code c in 1..3 asserts the chip strobe only in cycles where count mod 2^c equals 2^c−1. Code 0 keeps the chip strobe high on every cycle. The bus-master strobe equals the chip strobe.
- R6: Some rate codes are unused: 6 and 7 with the mode bit at 0, and 4 to 7 with the mode bit at 1. An unused code gives full speed, with the affected strobes high on every cycle.
- R7: The clock-output strobe equals the chip strobe on every cycle.
- R8: A written setting governs the strobes only from the cycle after one in which the cycle count is 31. In a count-31 cycle, all strobes are high. As a result, no strobe gap after a change is shorter than the old or the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write enable |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (reserved bits are 0) |
| bm_en | output | 1 | Bus-master clock-enable strobe |
| chip_en | output | 1 | Chip-wide clock-enable strobe |
| clkout_en | output | 1 | Clock-output pin enable strobe |

## Verification
The bench sends writes that set the reserved bits. A design that stored those bits would read back nonzero upper bits. Each unused rate code is tried in both modes. A design that decoded code 6 or code 4 as a real ratio would drop strobes that should stay high. Writes land at different points in the 32-cycle frame. A design that applied a new ratio at once, or on the old ratio's own boundary, would give a short strobe gap. That short gap differs from the reference model in the cycles just after the write. Mode changes show whether the bus-master strobe follows the chip strobe and whether the chip strobe stays at full speed with the mode bit clear.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int unsigned DATA_W        = 8;
  localparam int unsigned MODE_POS      = 5;
  localparam int unsigned SEL_W         = 3;
  localparam int unsigned PRE_W         = 5;
  localparam int unsigned BM_MAX_CODE   = 5;  // widest bus-master ratio is 2^5
  localparam int unsigned CHIP_MAX_CODE = 3;  // widest chip ratio is 2^3

  // Shift exponent (log2 of ratio) selected by a rate code; out-of-range codes mean full speed.
  function automatic int unsigned code_to_shift(logic [SEL_W-1:0] sel, int unsigned max_code);
    if (int'(sel) <= int'(max_code)) return int'(sel);
    return 0;
  endfunction

  function automatic int unsigned chip_shift(logic mode, logic [SEL_W-1:0] sel);
    if (!mode) return 0;
    return code_to_shift(sel, CHIP_MAX_CODE);
  endfunction

  function automatic int unsigned bm_shift(logic mode, logic [SEL_W-1:0] sel);
    if (mode) return chip_shift(mode, sel);
    return code_to_shift(sel, BM_MAX_CODE);
  endfunction
endpackage

// File: rtl/sysclk_prescaler.sv
module sysclk_prescaler #(
  parameter int unsigned PRE_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PRE_W-1:0] cnt,
  output logic             term
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign term = &cnt;
endmodule

// File: rtl/sysclk_cfg_reg.sv
module sysclk_cfg_reg #(
  parameter int unsigned DATA_W   = 8,
  parameter int unsigned MODE_POS = 5,
  parameter int unsigned SEL_W    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              apply,
  output logic              act_mode,
  output logic [SEL_W-1:0]  act_sel,
  output logic [DATA_W-1:0] rdata
);
  logic             prog_mode;
  logic [SEL_W-1:0] prog_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_mode <= 1'b0;
      prog_sel  <= '0;
      act_mode  <= 1'b0;
      act_sel   <= '0;
    end else begin
      if (we) begin
        prog_mode <= wdata[MODE_POS];
        prog_sel  <= wdata[SEL_W-1:0];
      end
      if (apply) begin
        act_mode <= prog_mode;
        act_sel  <= prog_sel;
      end
    end
  end

  always_comb begin
    rdata              = '0;
    rdata[MODE_POS]    = prog_mode;
    rdata[SEL_W-1:0]   = prog_sel;
  end
endmodule

// File: rtl/sysclk_strobe_gen.sv
module sysclk_strobe_gen
  import sysclk_pkg::*;
#(
  parameter int unsigned PRE_W = 5,
  parameter int unsigned SEL_W = 3
) (
  input  logic [PRE_W-1:0] cnt,
  input  logic             act_mode,
  input  logic [SEL_W-1:0] act_sel,
  output logic             bm_en,
  output logic             chip_en
);
  localparam int unsigned SH_W = $clog2(PRE_W + 1);

  logic [PRE_W:0]  tick;
  logic [SH_W-1:0] bm_k;
  logic [SH_W-1:0] chip_k;

  for (genvar k = 0; k <= PRE_W; k++) begin : g_tick
    if (k == 0) begin : g_full
      assign tick[k] = 1'b1;
    end else begin : g_div
      assign tick[k] = &cnt[k-1:0];
    end
  end

  always_comb begin
    bm_k    = SH_W'(bm_shift(act_mode, act_sel));
    chip_k  = SH_W'(chip_shift(act_mode, act_sel));
    bm_en   = tick[bm_k];
    chip_en = tick[chip_k];
  end
endmodule

// File: rtl/sysclk_rate_ctrl.sv
module sysclk_rate_ctrl
  import sysclk_pkg::*;
#(
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned MPOS = MODE_POS,
  parameter int unsigned SW   = SEL_W,
  parameter int unsigned PW   = PRE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          bm_en,
  output logic          chip_en,
  output logic          clkout_en
);
  logic [PW-1:0] pre_cnt;
  logic          pre_term;
  logic          act_mode;
  logic [SW-1:0] act_sel;

  sysclk_prescaler #(.PRE_W(PW)) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   (pre_cnt),
    .term  (pre_term)
  );

  sysclk_cfg_reg #(.DATA_W(DW), .MODE_POS(MPOS), .SEL_W(SW)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (reg_we),
    .wdata    (reg_wdata),
    .apply    (pre_term),
    .act_mode (act_mode),
    .act_sel  (act_sel),
    .rdata    (reg_rdata)
  );

  sysclk_strobe_gen #(.PRE_W(PW), .SEL_W(SW)) u_gen (
    .cnt      (pre_cnt),
    .act_mode (act_mode),
    .act_sel  (act_sel),
    .bm_en    (bm_en),
    .chip_en  (chip_en)
  );

  assign clkout_en = chip_en;
endmodule

// File: rtl/sysclk_rate_chk.sv
module sysclk_rate_chk #(
  parameter int unsigned DW   = 8,
  parameter int unsigned MPOS = 5,
  parameter int unsigned SW   = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_we,
  input logic [DW-1:0] reg_wdata,
  input logic [DW-1:0] reg_rdata,
  input logic          bm_en,
  input logic          chip_en,
  input logic          pre_term,
  input logic          act_mode,
  input logic [SW-1:0] act_sel
);
  localparam logic [DW-1:0] KEEP_MASK = (DW'(1) << MPOS) | DW'((1 << SW) - 1);

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~KEEP_MASK) == '0);  // R2
  AST_WRITE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> (reg_rdata == ($past(reg_wdata) & KEEP_MASK)));  // R2
  AST_CHIP_FULL_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
    !act_mode |-> chip_en);  // R4
  AST_BM_FOLLOWS_CHIP: assert property (@(posedge clk) disable iff (!rst_n)
    act_mode |-> (bm_en == chip_en));  // R5
  AST_ALL_FIRE_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    pre_term |-> (bm_en && chip_en));  // R8
  AST_APPLY_AT_TERM: assert property (@(posedge clk) disable iff (!rst_n)
    ({act_mode, act_sel} != $past({act_mode, act_sel})) |-> $past(pre_term));  // R8
endmodule

bind sysclk_rate_ctrl sysclk_rate_chk #(.DW(DW), .MPOS(MPOS), .SW(SW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_wdata (reg_wdata),
  .reg_rdata (reg_rdata),
  .bm_en     (bm_en),
  .chip_en   (chip_en),
  .pre_term  (pre_term),
  .act_mode  (act_mode),
  .act_sel   (act_sel)
);

// File: tb/sysclk_rate_ctrl_tb.sv
`timescale 1ns/1ps
module sysclk_rate_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       bm_en, chip_en, clkout_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit live = 1'b0;
  string phase = "R1";

  // Reference state
  int n_cyc = 0;
  int since_wr = 1000;
  bit m_mode = 1'b0, a_mode = 1'b0;
  int m_sel = 0, a_sel = 0;

  always #2.5 clk = ~clk;

  sysclk_rate_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .bm_en(bm_en), .chip_en(chip_en), .clkout_en(clkout_en)
  );

  function automatic int chip_ratio(bit mode, int sel);
    if (mode && sel >= 1 && sel <= 3) return 2 ** sel;
    return 1;
  endfunction

  function automatic int bm_ratio(bit mode, int sel);
    if (mode) return chip_ratio(mode, sel);
    if (sel >= 1 && sel <= 5) return 2 ** sel;
    return 1;
  endfunction

  function automatic bit fires(int n, int ratio);
    return (n % ratio) == (ratio - 1);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", req, what, act, exp, n_cyc);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_cyc = 0; m_mode = 0; m_sel = 0; a_mode = 0; a_sel = 0; since_wr = 1000;
    end else begin
      if ((n_cyc % 32) == 31) begin a_mode = m_mode; a_sel = m_sel; end
      if (reg_we) begin
        m_mode = reg_wdata[5]; m_sel = int'(reg_wdata[2:0]); since_wr = 0;
      end else if (since_wr < 1000) since_wr++;
      n_cyc++;
    end
  end

  always @(negedge clk) begin
    if (live && !done) begin
      string tag;
      tag = (since_wr <= 33) ? "R8" : phase;
      chk("R2", "rdata", int'(reg_rdata), (int'(m_mode) << 5) | m_sel);
      chk(tag, "bm_en", int'(bm_en), int'(fires(n_cyc, bm_ratio(a_mode, a_sel))));
      chk(a_mode ? tag : "R4", "chip_en", int'(chip_en), int'(fires(n_cyc, chip_ratio(a_mode, a_sel))));
      chk("R7", "clkout_en", int'(clkout_en), int'(chip_en));
    end
  end

  task automatic wr(logic [7:0] d);
    @(posedge clk); #1;
    reg_we = 1'b1; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic run(int cycles);
    repeat (cycles) @(posedge clk);
  endtask

  initial begin
    #500us;
    if (!done) begin
      done = 1'b1;
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset rdata", int'(reg_rdata), 0);
    chk("R1", "reset bm_en", int'(bm_en), 1);
    chk("R1", "reset chip_en", int'(chip_en), 1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    live = 1'b1;
    phase = "R1";
    run(40);
    // reserved bits set, unused code 7 in mode 0
    phase = "R6";
    wr(8'hDF);
    @(negedge clk);
    chk("R2", "reserved readback", int'(reg_rdata), 8'h07);
    run(70);
    phase = "R3";
    for (int c = 1; c <= 5; c++) begin
      wr(8'(c));
      run(70 + 3 * c);
    end
    phase = "R6";
    wr(8'h06);
    run(70);
    // back to /2, then jump to /32 mid-frame
    phase = "R3";
    wr(8'h01);
    run(45);
    wr(8'h05);
    run(80);
    // chip divide mode: mode bit first, then field
    phase = "R5";
    wr(8'h20);
    run(50);
    for (int c = 1; c <= 3; c++) begin
      wr(8'h20 | 8'(c));
      run(60 + 5 * c);
    end
    phase = "R6";
    for (int c = 4; c <= 7; c++) begin
      wr(8'h20 | 8'(c));
      run(60);
    end
    wr(8'hFF);
    @(negedge clk);
    chk("R2", "all-ones readback", int'(reg_rdata), 8'h27);
    run(60);
    phase = "R5";
    wr(8'h22);
    run(50);
    wr(8'h23);
    run(70);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule